// File: doc/BRIEF.md
# Picosecond Delay to Element Converter

This unit turns two requested pin delays, both given in picoseconds, into the coarse and fine delay-element counts of a single delay line. It then packs those counts into a 32-bit configuration word. One delay is "fixed": it is split against constant element periods of 920 ps (coarse) and 60 ps (fine). The other is "calibrated": it is split against coarse and fine element periods that a calibration step measured earlier. Both fine parts are kept in tenths of an element until they are summed, so rounding happens only once.

If the combined fine count is larger than 22, the unit folds the whole delay back into picoseconds and splits it again. This moves the excess into coarse elements. Every quotient comes from one shared shift-subtract divider, so a conversion takes several dozen cycles. The caller pulses `start` with the operands present. It then waits for the one-cycle `done` pulse, after which the word and flags are held until the next conversion completes.

Top module: `ps_delay_encoder`

## Requirements
- R1: After reset, `busy`, `done`, `crs_ovf`, `fin_ovf`, `period_err` are 0 and `cfg_word` is 0.
- R2: The fixed delay g contributes coarse g/920 and fine tenths ((g mod 920)·10)/60. Every division truncates toward zero.
- R3: The calibrated delay a contributes coarse a/C and fine tenths ((a mod C)·10)/F, where C is `crs_period` and F is `fin_period`, truncating.
- R4: The coarse count c is the sum of both coarse parts. The fine count f is the sum of both fine tenths divided by 10, truncating.
- R5: If f > 22, then T = c·C + f·F is computed, and the results become c = T/C and f = (T mod C)/F. If f ≤ 22, c and f are kept unchanged.
- R6: A coarse or fine count above 31 has only its low 5 bits placed in the word, and it raises `crs_ovf` or `fin_ovf` respectively.
- R7: In `cfg_word`, bits 17:12 hold 0x29 and bit 10 (lock) is 0. Bits 9:5 hold the coarse count and bits 4:0 hold the fine count. All other bits are 0.
- R8: A start with C = 0 or F = 0 performs no division. It gives `done` two cycles after the start edge, with `period_err` = 1, `cfg_word` = 0 and both overflow flags 0.
- R9: A start accepted while idle raises `busy` on the next cycle until the result is delivered. `done` is high for exactly one cycle. The outputs hold their values until the next `done`.
- R10: `start` is ignored while `busy` is high. The operands captured at the accepted start decide the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion with the operands present on this cycle |
| fixed_ps | input | DW | Fixed delay request in ps |
| cal_ps | input | DW | Calibrated delay request in ps |
| crs_period | input | PW | Calibrated coarse element period |
| fin_period | input | PW | Calibrated fine element period |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: result valid |
| cfg_word | output | 32 | Packed configuration word |
| crs_ovf | output | 1 | Coarse count exceeded its field |
| fin_ovf | output | 1 | Fine count exceeded its field |
| period_err | output | 1 | A calibrated period was zero |

## Verification
The bench builds the unit with DW = 10 and PW = 8. This shortens the divider to 21 steps per quotient, so several hundred complete conversions fit in the run. At these widths, a grid of fixed and calibrated delays, swept over the whole 10-bit range against five period pairs, reaches every path:
- pure fixed, pure calibrated and mixed splits;
- coarse overflow with unit periods;
- the renormalisation step, with a large coarse period over a small fine period;
- the 920 ps boundary;
- zero periods and a start issued mid-conversion.

// File: rtl/ps_delay_pkg.sv
package ps_delay_pkg;

  localparam int CFG_W    = 32;
  localparam int FLD_W    = 5;
  localparam int FIN_LSB  = 0;
  localparam int CRS_LSB  = 5;
  localparam int LOCK_POS = 10;
  localparam int SIG_LSB  = 12;
  localparam int SIG_W    = 6;
  localparam logic [SIG_W-1:0] SIG_VAL = 6'h29;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_G_CRS,
    ST_G_FIN,
    ST_A_CRS,
    ST_A_FIN,
    ST_F_SUM,
    ST_TOTAL,
    ST_R_CRS,
    ST_R_FIN,
    ST_PACK
  } conv_state_e;

endpackage

// File: rtl/ps_seq_divider.sv
module ps_seq_divider #(
  parameter int NW = 35
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] dividend,
  input  logic [NW-1:0] divisor,
  output logic          rdy,
  output logic [NW-1:0] quot,
  output logic [NW-1:0] rem
);

  localparam int CW = $clog2(NW + 1);

  logic          run;
  logic [CW-1:0] cnt;
  logic [NW-1:0] acc_r, acc_q, dvs_l, dvd_l;
  logic [NW:0]   trial;
  logic [NW-1:0] step_r, step_q;

  // one restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    trial = {acc_r, acc_q[NW-1]};
    if (trial >= {1'b0, dvs_l}) begin
      step_r = NW'(trial - {1'b0, dvs_l});
      step_q = {acc_q[NW-2:0], 1'b1};
    end else begin
      step_r = trial[NW-1:0];
      step_q = {acc_q[NW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      rdy   <= 1'b0;
      cnt   <= '0;
      acc_r <= '0;
      acc_q <= '0;
      dvs_l <= '0;
      dvd_l <= '0;
    end else begin
      rdy <= 1'b0;
      if (go && !run) begin
        run   <= 1'b1;
        cnt   <= CW'(NW);
        acc_r <= '0;
        acc_q <= dividend;
        dvs_l <= divisor;
        dvd_l <= dividend;
      end else if (run) begin
        acc_r <= step_r;
        acc_q <= step_q;
        cnt   <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          rdy <= 1'b1;
        end
      end
    end
  end

  assign quot = acc_q;
  assign rem  = acc_r;

  logic [2*NW-1:0] recon;
  assign recon = (2*NW)'(acc_q) * (2*NW)'(dvs_l) + (2*NW)'(acc_r);

  // R2 truncating division: q*d + r == n and r < d
  a_r2_div_exact: assert property (@(posedge clk) disable iff (rst)
    rdy |-> (recon == (2*NW)'(dvd_l)) && (acc_r < dvs_l));

  // R9 launches only reach an idle divider
  a_r9_go_when_idle: assert property (@(posedge clk) disable iff (rst)
    go |-> !run);

endmodule

// File: rtl/ps_word_packer.sv
module ps_word_packer
  import ps_delay_pkg::*;
#(
  parameter int NW = 35
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             err_in,
  input  logic [NW-1:0]    crs_in,
  input  logic [NW-1:0]    fin_in,
  output logic [CFG_W-1:0] cfg_word,
  output logic             crs_ovf,
  output logic             fin_ovf,
  output logic             period_err
);

  localparam int NF = 2;
  localparam int FLD_POS [NF] = '{CRS_LSB, FIN_LSB};

  logic [NF-1:0][NW-1:0]    cnt_in;
  logic [NF-1:0][FLD_W-1:0] fld_val;
  logic [NF-1:0]            fld_ovf;
  logic [CFG_W-1:0]         word_c;

  assign cnt_in[0] = crs_in;
  assign cnt_in[1] = fin_in;

  for (genvar gi = 0; gi < NF; gi++) begin : g_fld
    assign fld_val[gi] = cnt_in[gi][FLD_W-1:0];
    assign fld_ovf[gi] = |cnt_in[gi][NW-1:FLD_W];
  end

  always_comb begin
    word_c = '0;
    word_c[SIG_LSB +: SIG_W] = SIG_VAL;
    word_c[LOCK_POS] = 1'b0;
    for (int k = 0; k < NF; k++) begin
      word_c[FLD_POS[k] +: FLD_W] = fld_val[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_word   <= '0;
      crs_ovf    <= 1'b0;
      fin_ovf    <= 1'b0;
      period_err <= 1'b0;
    end else if (load) begin
      if (err_in) begin
        cfg_word   <= '0;
        crs_ovf    <= 1'b0;
        fin_ovf    <= 1'b0;
        period_err <= 1'b1;
      end else begin
        cfg_word   <= word_c;
        crs_ovf    <= fld_ovf[0];
        fin_ovf    <= fld_ovf[1];
        period_err <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ps_delay_encoder.sv
module ps_delay_encoder
  import ps_delay_pkg::*;
#(
  parameter int DW            = 16,
  parameter int PW            = 16,
  parameter int FIX_COARSE_PS = 920,
  parameter int FIX_FINE_PS   = 60,
  parameter int FINE_LIMIT    = 22,
  parameter int TENTHS        = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DW-1:0]    fixed_ps,
  input  logic [DW-1:0]    cal_ps,
  input  logic [PW-1:0]    crs_period,
  input  logic [PW-1:0]    fin_period,
  output logic             busy,
  output logic             done,
  output logic [CFG_W-1:0] cfg_word,
  output logic             crs_ovf,
  output logic             fin_ovf,
  output logic             period_err
);

  localparam int MW = (DW > PW) ? DW : PW;
  localparam int NW = MW + PW + 3;
  localparam logic [NW-1:0] FIX_C_W   = NW'(FIX_COARSE_PS);
  localparam logic [NW-1:0] FIX_F_W   = NW'(FIX_FINE_PS);
  localparam logic [NW-1:0] TEN_W     = NW'(TENTHS);
  localparam logic [NW-1:0] FIN_LIM_W = NW'(FINE_LIMIT);

  conv_state_e   state;
  logic [DW-1:0] fix_lat, cal_lat;
  logic [PW-1:0] cp_lat, fp_lat;
  logic [NW-1:0] crs_acc, fin_acc, tenth_acc, tmp_rem;
  logic          issued, err_r, done_r;

  logic          div_stage, div_go, div_rdy;
  logic [NW-1:0] div_n, div_d, div_q, div_r;
  logic [NW-1:0] tot_w;

  assign div_stage = (state == ST_G_CRS) || (state == ST_G_FIN) ||
                     (state == ST_A_CRS) || (state == ST_A_FIN) ||
                     (state == ST_F_SUM) || (state == ST_R_CRS) ||
                     (state == ST_R_FIN);
  assign div_go = div_stage && !issued;

  always_comb begin
    div_n = '0;
    div_d = TEN_W;
    case (state)
      ST_G_CRS: begin div_n = NW'(fix_lat);      div_d = FIX_C_W;     end
      ST_G_FIN: begin div_n = tmp_rem * TEN_W;   div_d = FIX_F_W;     end
      ST_A_CRS: begin div_n = NW'(cal_lat);      div_d = NW'(cp_lat); end
      ST_A_FIN: begin div_n = tmp_rem * TEN_W;   div_d = NW'(fp_lat); end
      ST_F_SUM: begin div_n = tenth_acc;         div_d = TEN_W;       end
      ST_R_CRS: begin div_n = tmp_rem;           div_d = NW'(cp_lat); end
      ST_R_FIN: begin div_n = tmp_rem;           div_d = NW'(fp_lat); end
      default:  begin div_n = '0;                div_d = TEN_W;       end
    endcase
  end

  assign tot_w = crs_acc * NW'(cp_lat) + fin_acc * NW'(fp_lat);

  ps_seq_divider #(.NW(NW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (div_go),
    .dividend (div_n),
    .divisor  (div_d),
    .rdy      (div_rdy),
    .quot     (div_q),
    .rem      (div_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      fix_lat   <= '0;
      cal_lat   <= '0;
      cp_lat    <= '0;
      fp_lat    <= '0;
      crs_acc   <= '0;
      fin_acc   <= '0;
      tenth_acc <= '0;
      tmp_rem   <= '0;
      issued    <= 1'b0;
      err_r     <= 1'b0;
      done_r    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (div_go) issued <= 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          fix_lat   <= fixed_ps;
          cal_lat   <= cal_ps;
          cp_lat    <= crs_period;
          fp_lat    <= fin_period;
          crs_acc   <= '0;
          fin_acc   <= '0;
          tenth_acc <= '0;
          if ((crs_period == '0) || (fin_period == '0)) begin
            err_r <= 1'b1;
            state <= ST_PACK;
          end else begin
            err_r <= 1'b0;
            state <= ST_G_CRS;
          end
        end
        ST_G_CRS: if (div_rdy) begin
          crs_acc <= div_q;
          tmp_rem <= div_r;
          issued  <= 1'b0;
          state   <= ST_G_FIN;
        end
        ST_G_FIN: if (div_rdy) begin
          tenth_acc <= div_q;
          issued    <= 1'b0;
          state     <= ST_A_CRS;
        end
        ST_A_CRS: if (div_rdy) begin
          crs_acc <= crs_acc + div_q;
          tmp_rem <= div_r;
          issued  <= 1'b0;
          state   <= ST_A_FIN;
        end
        ST_A_FIN: if (div_rdy) begin
          tenth_acc <= tenth_acc + div_q;
          issued    <= 1'b0;
          state     <= ST_F_SUM;
        end
        ST_F_SUM: if (div_rdy) begin
          fin_acc <= div_q;
          issued  <= 1'b0;
          state   <= (div_q > FIN_LIM_W) ? ST_TOTAL : ST_PACK;
        end
        ST_TOTAL: begin
          tmp_rem <= tot_w;
          state   <= ST_R_CRS;
        end
        ST_R_CRS: if (div_rdy) begin
          crs_acc <= div_q;
          tmp_rem <= div_r;
          issued  <= 1'b0;
          state   <= ST_R_FIN;
        end
        ST_R_FIN: if (div_rdy) begin
          fin_acc <= div_q;
          issued  <= 1'b0;
          state   <= ST_PACK;
        end
        ST_PACK: begin
          done_r <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  ps_word_packer #(.NW(NW)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .load       (state == ST_PACK),
    .err_in     (err_r),
    .crs_in     (crs_acc),
    .fin_in     (fin_acc),
    .cfg_word   (cfg_word),
    .crs_ovf    (crs_ovf),
    .fin_ovf    (fin_ovf),
    .period_err (period_err)
  );

  assign busy = (state != ST_IDLE);
  assign done = done_r;

  // R9 done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10 captured operands stay put while a conversion runs
  a_r10_hold_operands: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(fix_lat) && $stable(cal_lat) && $stable(cp_lat) && $stable(fp_lat));

  // R8 a zero period finishes two cycles later with the error flag
  a_r8_zero_short: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && ((crs_period == '0) || (fin_period == '0)))
      |-> ##2 (done && period_err));

  // R7 fixed fields of a good word
  a_r7_word_format: assert property (@(posedge clk) disable iff (rst)
    (done && !period_err) |->
      (cfg_word[SIG_LSB +: SIG_W] == SIG_VAL) && !cfg_word[LOCK_POS] &&
      (cfg_word[CFG_W-1:SIG_LSB+SIG_W] == '0) &&
      (cfg_word[LOCK_POS+1 +: SIG_LSB-LOCK_POS-1] == '0));

  // R5 the fold-back step is entered only for a large fine count
  a_r5_renorm_gate: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TOTAL) |-> (fin_acc > FIN_LIM_W));

endmodule

// File: tb/tb_ps_delay_encoder.sv
`timescale 1ns/1ps
module tb_ps_delay_encoder;

  localparam int BDW = 10;
  localparam int BPW = 8;

  logic           clk = 1'b0;
  logic           rst;
  logic           start;
  logic [BDW-1:0] fixed_ps, cal_ps;
  logic [BPW-1:0] crs_period, fin_period;
  logic           busy, done, crs_ovf, fin_ovf, period_err;
  logic [31:0]    cfg_word;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ps_delay_encoder #(.DW(BDW), .PW(BPW)) dut (
    .clk(clk), .rst(rst), .start(start),
    .fixed_ps(fixed_ps), .cal_ps(cal_ps),
    .crs_period(crs_period), .fin_period(fin_period),
    .busy(busy), .done(done), .cfg_word(cfg_word),
    .crs_ovf(crs_ovf), .fin_ovf(fin_ovf), .period_err(period_err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input longint g, input longint a,
                                input longint cd, input longint fd,
                                output longint c, output longint f,
                                output bit ren);
    longint gc, gf, ac, af, t;
    gc = g / 920;
    gf = ((g % 920) * 10) / 60;
    ac = a / cd;
    af = ((a % cd) * 10) / fd;
    c  = gc + ac;
    f  = (gf + af) / 10;
    ren = 0;
    if (f > 22) begin
      ren = 1;
      t = c * cd + f * fd;
      c = t / cd;
      f = (t % cd) / fd;
    end
  endfunction

  task automatic launch(input int g, input int a, input int cd, input int fd);
    @(negedge clk);
    fixed_ps   = BDW'(g);
    cal_ps     = BDW'(a);
    crs_period = BPW'(cd);
    fin_period = BPW'(fd);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk({tag, " timeout"}, 0, 1);
  endtask

  task automatic conv(input int g, input int a, input int cd, input int fd);
    longint c, f, wexp;
    bit ren;
    string tag;
    logic [31:0] seen;
    model(g, a, cd, fd, c, f, ren);
    if (ren) tag = "R5";
    else if (a == 0) tag = "R2";
    else if (g == 0) tag = "R3";
    else tag = "R4";
    wexp = (longint'(41) << 12) | ((c & 31) << 5) | (f & 31);
    launch(g, a, cd, fd);
    wait_done(tag);
    chk(tag, cfg_word, wexp);
    chk("R6 coarse flag", crs_ovf, (c > 31) ? 1 : 0);
    chk("R6 fine flag", fin_ovf, (f > 31) ? 1 : 0);
    chk("R7 fixed bits", cfg_word & 32'hFFFF_FC00, 32'h0002_9000);
    chk("R8 no error", period_err, 0);
    seen = cfg_word;
    @(negedge clk);
    chk("R9 done single", done, 0);
    chk("R9 hold", cfg_word, seen);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int cds [5] = '{1, 3, 45, 200, 255};
    int fds [5] = '{1, 1, 7, 5, 255};
    rst = 1'b1; start = 1'b0;
    fixed_ps = '0; cal_ps = '0; crs_period = '0; fin_period = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 word", cfg_word, 0);
    chk("R1 flags", {crs_ovf, fin_ovf, period_err}, 0);

    // R8 zero coarse period
    launch(300, 200, 0, 5);
    chk("R8 not yet", done, 0);
    @(negedge clk);
    chk("R8 done timing", done, 1);
    chk("R8 err", period_err, 1);
    chk("R8 word", cfg_word, 0);
    chk("R8 flags", {crs_ovf, fin_ovf}, 0);
    // R8 zero fine period
    launch(300, 200, 45, 0);
    @(negedge clk);
    chk("R8 fine zero done", done, 1);
    chk("R8 fine zero err", period_err, 1);

    // R9 / R10 busy and ignored start
    launch(500, 300, 45, 7);
    chk("R9 busy", busy, 1);
    repeat (5) @(negedge clk);
    fixed_ps = 10'd0; cal_ps = 10'd1000; crs_period = 8'd0; fin_period = 8'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10");
    begin
      longint c, f; bit ren;
      model(500, 300, 45, 7, c, f, ren);
      chk("R10 first operands win", cfg_word,
          (longint'(41) << 12) | ((c & 31) << 5) | (f & 31));
      chk("R10 no error", period_err, 0);
    end
    @(negedge clk);
    chk("R9 idle after", busy, 0);

    // boundary cases
    conv(919, 0, 200, 5);
    conv(920, 0, 200, 5);
    conv(59, 0, 1, 1);
    conv(60, 0, 1, 1);
    conv(1023, 1023, 1, 1);
    conv(1023, 1023, 255, 255);
    conv(0, 199, 200, 5);
    conv(0, 1023, 200, 1);

    // sweep
    for (int p = 0; p < 5; p++)
      for (int g = 0; g < 1024; g += 79)
        for (int a = 0; a < 1024; a += 113)
          conv(g, a, cds[p], fds[p]);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule